// File: doc/BRIEF.md
# Two-stage watchdog timer

This block watches a free-running 64-bit system count supplied from outside. Software arms it through a control frame and keeps it alive by writing a separate refresh frame. Each refresh sets a deadline equal to the present count plus a 32-bit period. If the count reaches that deadline, the first stage raises an interrupt and sets a new deadline one period later. If that second deadline also passes with no refresh, the second stage raises a reset request. With no refresh at all, the reset request arrives two periods after the last refresh.

The second-stage flag stays set until the power-on reset input. Software can read it after a reboot to learn that the watchdog caused the reset. Both frames use a plain register bus. The block always accepts a request on the cycle it is presented. Read data comes back one cycle later, together with a one-cycle valid strobe. There is no back-pressure in either direction.

Top module: `wdog_two_stage`

## Requirements
- R1: After `rst_n` is low, enable, first-stage and second-stage flags read 0, `wdog_irq` and `wdog_reset` are low, the period reads `RST_PERIOD`, and the deadline reads 0.
- R2: Control word at control-frame address 0x000: bit 0 is the enable (read/write), bit 1 is the first-stage flag, bit 2 is the second-stage flag (both read-only). A read presents data and a high `cf_rvalid` in the cycle after the request (same for `rf_rvalid`).
- R3: The 32-bit period sits at control-frame address 0x008 (read/write). Writing it is a refresh that already uses the newly written period.
- R4: The 64-bit deadline is read and written as two 32-bit halves: low at 0x010, high at 0x014.
- R5: A refresh is a write of any data to refresh-frame address 0x000, or any write to the control word or the period. It sets deadline = count + period (zero-extended) and clears the first-stage flag.
- R6: While enabled, with the first-stage flag clear and count >= deadline (unsigned), the next clock edge sets the first-stage flag and `wdog_irq`. It also reloads the deadline with count + period.
- R7: While enabled, with the first-stage flag set and count >= deadline, the next clock edge sets the second-stage flag and `wdog_reset`.
- R8: The second-stage flag is cleared only by `rst_n`. Refreshes and disabling do not clear it. Once it is set, no further expiry is evaluated.
- R9: While the enable bit is 0, neither flag can become set, whatever the count.
- R10: Address 0xFCC reads `ID_VALUE` in both frames. Unmapped addresses and the refresh word read 0. Writes to read-only words change nothing.
- R11: If a refresh and an expiry fall in the same cycle, the refresh wins. No flag is set, and the deadline becomes count + period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| sys_count | input | 64 | Free-running system count |
| cf_req | input | 1 | Control-frame request |
| cf_we | input | 1 | Control-frame write (1) or read (0) |
| cf_addr | input | 12 | Control-frame byte address |
| cf_wdata | input | 32 | Control-frame write data |
| cf_rdata | output | 32 | Control-frame read data |
| cf_rvalid | output | 1 | Control-frame read data valid |
| rf_req | input | 1 | Refresh-frame request |
| rf_we | input | 1 | Refresh-frame write (1) or read (0) |
| rf_addr | input | 12 | Refresh-frame byte address |
| rf_rdata | output | 32 | Refresh-frame read data |
| rf_rvalid | output | 1 | Refresh-frame read data valid |
| wdog_irq | output | 1 | First-stage interrupt |
| wdog_reset | output | 1 | Second-stage reset request |

## Verification
The hardest case to reach from the ports is a refresh that lands in the very cycle the count meets the deadline. It must beat the expiry. Only one count value and one bus cycle line up for it. The bench drives the system count directly, so it can put the count exactly one below and exactly on each computed deadline, and issue the refresh write in that same cycle. Random periods and base counts then walk both stages many times, with a power-on reset between runs that end in the second stage.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 64;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] A_PER   = 12'h008;
  localparam logic [ADDR_W-1:0] A_DLO   = 12'h010;
  localparam logic [ADDR_W-1:0] A_DHI   = 12'h014;
  localparam logic [ADDR_W-1:0] A_IDENT = 12'hFCC;
  localparam logic [ADDR_W-1:0] A_KICK  = 12'h000;

  typedef struct packed {
    logic              kick;
    logic              dl_lo_we;
    logic              dl_hi_we;
    logic [DATA_W-1:0] data;
  } ctl_cmd_t;
endpackage

// File: rtl/wdog_ctrl_frame.sv
module wdog_ctrl_frame
  import wdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_PERIOD = 32'd1000,
  parameter logic [DATA_W-1:0] ID_VALUE   = 32'h0210_57D3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  deadline,
  input  logic              stage1,
  input  logic              stage2,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              enable,
  output logic [DATA_W-1:0] period_eff,
  output ctl_cmd_t          cmd
);
  logic [DATA_W-1:0] period_q;
  logic              wr_ctrl, wr_per;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl = req && we && (addr == A_CTRL);
  assign wr_per  = req && we && (addr == A_PER);

  // a period write takes effect in the refresh it triggers
  assign period_eff = wr_per ? wdata : period_q;

  always_comb begin
    cmd.kick     = wr_ctrl || wr_per;
    cmd.dl_lo_we = req && we && (addr == A_DLO);
    cmd.dl_hi_we = req && we && (addr == A_DHI);
    cmd.data     = wdata;
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rd_mux = {{(DATA_W-3){1'b0}}, stage2, stage1, enable};
      A_PER:   rd_mux = period_q;
      A_DLO:   rd_mux = deadline[DATA_W-1:0];
      A_DHI:   rd_mux = deadline[CNT_W-1:DATA_W];
      A_IDENT: rd_mux = ID_VALUE;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      period_q <= RST_PERIOD;
      rdata    <= '0;
      rvalid   <= 1'b0;
    end else begin
      if (wr_ctrl) enable <= wdata[0];
      if (wr_per)  period_q <= wdata;
      rvalid <= req && !we;
      if (req && !we) rdata <= rd_mux;
    end
  end

  a_r3_period_write_kicks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_per |=> (period_q == $past(wdata)));
endmodule

// File: rtl/wdog_refresh_frame.sv
module wdog_refresh_frame
  import wdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0210_57D3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              kick
);
  assign kick = req && we && (addr == A_KICK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= req && !we;
      if (req && !we) rdata <= (addr == A_IDENT) ? ID_VALUE : '0;
    end
  end
endmodule

// File: rtl/wdog_stage_seq.sv
module wdog_stage_seq
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              kick,
  input  logic              dl_lo_we,
  input  logic              dl_hi_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] period,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  deadline,
  output logic              stage1,
  output logic              stage2
);
  localparam int PAD_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] next_dl;
  logic             due, advance;

  assign next_dl = count + {{PAD_W{1'b0}}, period};
  assign due     = (count >= deadline);
  assign advance = enable && !stage2 && due && !kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deadline <= '0;
      stage1   <= 1'b0;
      stage2   <= 1'b0;
    end else if (kick) begin
      deadline <= next_dl;
      stage1   <= 1'b0;
    end else if (advance) begin
      if (!stage1) begin
        stage1   <= 1'b1;
        deadline <= next_dl;
      end else begin
        stage2   <= 1'b1;
      end
    end else begin
      if (dl_lo_we) deadline[DATA_W-1:0]     <= wdata;
      if (dl_hi_we) deadline[CNT_W-1:DATA_W] <= wdata;
    end
  end

  a_r8_stage2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stage2 |=> stage2);
  a_r7_stage2_after_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage2) |-> $past(stage1));
  a_r5_kick_clears_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !stage1);
  a_r9_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !$rose(stage1) && !$rose(stage2));
  a_r6_stage1_needs_due: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage1) |-> $past(enable) && $past(count >= deadline));
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_PERIOD = 32'd1000,
  parameter logic [DATA_W-1:0] ID_VALUE   = 32'h0210_57D3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_count,
  input  logic              cf_req,
  input  logic              cf_we,
  input  logic [ADDR_W-1:0] cf_addr,
  input  logic [DATA_W-1:0] cf_wdata,
  output logic [DATA_W-1:0] cf_rdata,
  output logic              cf_rvalid,
  input  logic              rf_req,
  input  logic              rf_we,
  input  logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_rdata,
  output logic              rf_rvalid,
  output logic              wdog_irq,
  output logic              wdog_reset
);
  ctl_cmd_t          cmd;
  logic              enable, rf_kick, stage1, stage2;
  logic [DATA_W-1:0] period_eff;
  logic [CNT_W-1:0]  deadline;

  wdog_ctrl_frame #(.RST_PERIOD(RST_PERIOD), .ID_VALUE(ID_VALUE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(cf_req), .we(cf_we), .addr(cf_addr),
    .wdata(cf_wdata), .deadline(deadline), .stage1(stage1), .stage2(stage2),
    .rdata(cf_rdata), .rvalid(cf_rvalid), .enable(enable),
    .period_eff(period_eff), .cmd(cmd));

  wdog_refresh_frame #(.ID_VALUE(ID_VALUE)) u_kick (
    .clk(clk), .rst_n(rst_n), .req(rf_req), .we(rf_we), .addr(rf_addr),
    .rdata(rf_rdata), .rvalid(rf_rvalid), .kick(rf_kick));

  wdog_stage_seq u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .kick(cmd.kick || rf_kick),
    .dl_lo_we(cmd.dl_lo_we), .dl_hi_we(cmd.dl_hi_we), .wdata(cmd.data),
    .period(period_eff), .count(sys_count), .deadline(deadline),
    .stage1(stage1), .stage2(stage2));

  assign wdog_irq   = stage1;
  assign wdog_reset = stage2;
endmodule

// File: tb/wdog_two_stage_test.sv
`timescale 1ns/1ps
module wdog_two_stage_test;
  localparam logic [31:0] RST_PER = 32'd1000;
  localparam logic [31:0] IDV     = 32'h0210_57D3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_count = '0;
  logic        cf_req = 1'b0, cf_we = 1'b0;
  logic [11:0] cf_addr = '0;
  logic [31:0] cf_wdata = '0;
  logic [31:0] cf_rdata;
  logic        cf_rvalid;
  logic        rf_req = 1'b0, rf_we = 1'b0;
  logic [11:0] rf_addr = '0;
  logic [31:0] rf_rdata;
  logic        rf_rvalid;
  logic        wdog_irq, wdog_reset;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  wdog_two_stage #(.RST_PERIOD(RST_PER), .ID_VALUE(IDV)) uut (
    .clk(clk), .rst_n(rst_n), .sys_count(sys_count),
    .cf_req(cf_req), .cf_we(cf_we), .cf_addr(cf_addr), .cf_wdata(cf_wdata),
    .cf_rdata(cf_rdata), .cf_rvalid(cf_rvalid),
    .rf_req(rf_req), .rf_we(rf_we), .rf_addr(rf_addr),
    .rf_rdata(rf_rdata), .rf_rvalid(rf_rvalid),
    .wdog_irq(wdog_irq), .wdog_reset(wdog_reset));

  function automatic logic [63:0] deadline_of(logic [63:0] c, logic [31:0] p);
    return c + {32'b0, p};
  endfunction

  function automatic logic [31:0] ctrl_word(logic en, logic s1, logic s2);
    return {29'b0, s2, s1, en};
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cwr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    cf_req = 1'b1; cf_we = 1'b1; cf_addr = a; cf_wdata = d;
    @(negedge clk);
    cf_req = 1'b0; cf_we = 1'b0;
  endtask

  task automatic crd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cf_req = 1'b1; cf_we = 1'b0; cf_addr = a;
    @(negedge clk);
    cf_req = 1'b0;
    d = cf_rdata;
    chk("R2 rvalid", {63'b0, cf_rvalid}, 64'd1);
  endtask

  task automatic rrd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rf_req = 1'b1; rf_we = 1'b0; rf_addr = a;
    @(negedge clk);
    rf_req = 1'b0;
    d = rf_rdata;
    chk("R2 rf_rvalid", {63'b0, rf_rvalid}, 64'd1);
  endtask

  task automatic kick();
    @(negedge clk);
    rf_req = 1'b1; rf_we = 1'b1; rf_addr = 12'h000;
    @(negedge clk);
    rf_req = 1'b0; rf_we = 1'b0;
  endtask

  task automatic read_dl(output logic [63:0] dl);
    logic [31:0] lo, hi;
    crd(12'h010, lo);
    crd(12'h014, hi);
    dl = {hi, lo};
  endtask

  task automatic power_on();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_count(logic [63:0] c);
    @(negedge clk);
    sys_count = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] dl, base;
    logic [31:0] per;
    void'($urandom(32'd1234));

    power_on();
    // R1 reset state
    chk("R1 irq", {63'b0, wdog_irq}, 0);
    chk("R1 reset", {63'b0, wdog_reset}, 0);
    crd(12'h000, d); chk("R1 ctrl", {32'b0, d}, 0);
    crd(12'h008, d); chk("R1 period", {32'b0, d}, {32'b0, RST_PER});
    read_dl(dl); chk("R1 deadline", dl, 0);

    // R10 identification and unmapped
    crd(12'hFCC, d); chk("R10 id ctrl", {32'b0, d}, {32'b0, IDV});
    rrd(12'hFCC, d); chk("R10 id refresh", {32'b0, d}, {32'b0, IDV});
    rrd(12'h000, d); chk("R10 refresh word", {32'b0, d}, 0);
    crd(12'h100, d); chk("R10 unmapped", {32'b0, d}, 0);
    cwr(12'hFCC, 32'h0);
    crd(12'hFCC, d); chk("R10 id unchanged", {32'b0, d}, {32'b0, IDV});

    // R4 deadline halves writable
    cwr(12'h010, 32'hDEAD_0001);
    cwr(12'h014, 32'h0000_0077);
    read_dl(dl); chk("R4 deadline rw", dl, 64'h0000_0077_DEAD_0001);

    // R9 disabled: no stage even when count far past deadline
    set_count(64'hFFFF_0000_0000_0000);
    repeat (3) @(negedge clk);
    chk("R9 irq disabled", {63'b0, wdog_irq}, 0);
    crd(12'h000, d); chk("R9 ctrl disabled", {32'b0, d}, 0);

    // R11 refresh coincides with expiry
    set_count(64'd500);
    cwr(12'h000, 32'h1);          // enable, refresh: deadline 1500
    crd(12'h000, d); chk("R2 enable bit", {32'b0, d}, {32'b0, ctrl_word(1, 0, 0)});
    @(negedge clk);
    sys_count = 64'd1500;
    rf_req = 1'b1; rf_we = 1'b1; rf_addr = 12'h000;
    @(negedge clk);
    rf_req = 1'b0; rf_we = 1'b0;
    chk("R11 no stage", {63'b0, wdog_irq}, 0);
    read_dl(dl); chk("R11 deadline", dl, 64'd2500);

    // random sequences of both stages
    for (int it = 0; it < 40; it++) begin
      per  = ($urandom() & 32'h0FFF_FFFF) + 32'd2;
      base = {2'b0, $urandom() & 30'h3FFF_FFFF, $urandom()};
      power_on();
      set_count(base);
      cwr(12'h000, 32'h1);
      cwr(12'h008, per);          // R3 refresh with new period
      read_dl(dl); chk("R3 refresh uses new period", dl, deadline_of(base, per));
      set_count(deadline_of(base, per) - 64'd1);
      chk("R6 not yet due", {63'b0, wdog_irq}, 0);
      set_count(deadline_of(base, per));
      chk("R6 irq", {63'b0, wdog_irq}, 1);
      crd(12'h000, d); chk("R6 ctrl", {32'b0, d}, {32'b0, ctrl_word(1, 1, 0)});
      read_dl(dl); chk("R6 reload", dl, deadline_of(deadline_of(base, per), per));
      if ($urandom() % 2 == 0) begin
        base = deadline_of(base, per) + 64'd7;
        set_count(base);
        kick();
        chk("R5 refresh clears irq", {63'b0, wdog_irq}, 0);
        read_dl(dl); chk("R5 deadline", dl, deadline_of(base, per));
      end else begin
        set_count(deadline_of(deadline_of(base, per), per) - 64'd1);
        chk("R7 not yet", {63'b0, wdog_reset}, 0);
        set_count(deadline_of(deadline_of(base, per), per));
        chk("R7 reset", {63'b0, wdog_reset}, 1);
        kick();
        cwr(12'h000, 32'h0);
        crd(12'h000, d); chk("R8 sticky", {32'b0, d}, {32'b0, ctrl_word(0, 0, 1)});
        chk("R8 reset out", {63'b0, wdog_reset}, 1);
        cwr(12'h000, 32'h1);
        set_count(64'hFFFF_FFFF_FFFF_0000);
        crd(12'h000, d); chk("R8 frozen", {32'b0, d}, {32'b0, ctrl_word(1, 0, 1)});
      end
    end

    power_on();
    chk("R1 reset clears stage2", {63'b0, wdog_reset}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule